// File: doc/BRIEF.md
# Segmented Switch Decoder with Dual Return-to-Zero Expansion

This block converts one 14-bit sample word per sample period into the switch-control pattern of a segmented current-steering converter. The six most significant bits select how many of 63 equal-weight unit switches are on, using a thermometer code. The eight least significant bits drive eight binary-weighted switches directly, with no decoding. The result is 71 switch signals.

Each switch signal then becomes four registered control lines: a true leg and a complement leg for each of two return-to-zero copies. The first copy is live in the first half of the sample period and is zero in the second half. The second copy carries the same sample and is live only in the second half. Summed, the two copies hold the sample value for the whole period. The 284-line bus leaves the block registered on one clock edge.

The block runs on a clock at twice the sample rate. An internal half-period indicator keeps the two copies synchronous, and a port shows which half the bus is currently presenting.

Top module: `seg_drtz_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `sw_bus` and `half_o` is 0 after that edge.
- R2: After reset, `half_o` alternates on every rising edge; the first edge after reset release sets it to 1. A value of 0 marks the first half of a sample period and 1 marks the second half.
- R3: Bus group k (bits 4k to 4k+3, k = 0..62) carries thermometer switch k. That switch is on exactly when `sample_in[13:8]` is greater than k, so a field value n turns on exactly n groups.
- R4: Bus group 63+j (j = 0..7) carries binary switch j, which equals bit j of the captured word.
- R5: Within each group, bit offset 0 is copy A true, 1 is copy A complement, 2 is copy B true and 3 is copy B complement. While `half_o` is 0, copy A equals the switch value and its complement, and both copy B bits are 0.
- R6: While `half_o` is 1, both copy A bits are 0, and copy B shows the switch value and its complement for the same sample that copy A showed in the preceding half.
- R7: In each half period, the sum of the weights of the live true lines equals the sample code. A thermometer group weighs 256 and binary switch j weighs 2^j.
- R8: `sample_in` is captured only on a rising edge after which `half_o` reads 1. Its first-half pattern appears after the next edge and its second-half pattern after the edge following that. A value presented at any other edge has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 14 | Sample word, upper 6 bits thermometer field, lower 8 bits binary field |
| half_o | output | 1 | Half period shown on the bus, 0 first, 1 second |
| sw_bus | output | 284 | Registered switch-control lines, four per switch |

## Verification
Every one of the 16384 sample codes is applied in turn. Each code is checked in both halves of its period against a bus image built arithmetically from the code. The sweep covers the empty and full thermometer field and every binary bit pattern under every thermometer count, which separates errors in the thermometer boundary (off by one at each k) from errors in the binary bit order. Counting live thermometer groups and summing weighted currents in each half separates a wrongly gated copy from a wrong switch value. Between captures, the bench drives the bitwise inverse of the code on the input, so a capture at the wrong edge shows up as a mismatched first-half pattern.

// File: rtl/seg_drtz_pkg.sv
package seg_drtz_pkg;
  typedef enum logic {HALF_A = 1'b0, HALF_B = 1'b1} half_e;
  localparam int LINES_PER_SW = 4;
  localparam int OFS_A  = 0;
  localparam int OFS_AN = 1;
  localparam int OFS_B  = 2;
  localparam int OFS_BN = 3;
endpackage

// File: rtl/seg_phase_ctl.sv
module seg_phase_ctl
  import seg_drtz_pkg::*;
#(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] sample_in,
  output half_e             half_q,
  output logic [WORD_W-1:0] word_q
);
  // Half indicator toggles every edge; the word is taken at the period start.
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_A;
      word_q <= '0;
    end else begin
      half_q <= (half_q == HALF_A) ? HALF_B : HALF_A;
      if (half_q == HALF_A) word_q <= sample_in;
    end
  end

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (half_q == HALF_B) |=> $stable(word_q)); // R8

  AST_HALF_FLIP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (half_q != $past(half_q))); // R2
endmodule

// File: rtl/seg_therm_dec.sv
module seg_therm_dec #(
  parameter int FIELD_W = 6,
  localparam int LINES  = (1 << FIELD_W) - 1
) (
  input  logic [FIELD_W-1:0] field,
  output logic [LINES-1:0]   therm
);
  always_comb begin
    for (int k = 0; k < LINES; k++) begin
      therm[k] = (int'(field) > k);
    end
    if (!$isunknown(field)) begin
      AST_THERM_COUNT: assert ($countones(therm) == int'(field)); // R3
    end
  end
endmodule

// File: rtl/seg_drtz_lane.sv
module seg_drtz_lane
  import seg_drtz_pkg::*;
(
  input  logic                    sw,
  input  half_e                   half,
  output logic [LINES_PER_SW-1:0] lines
);
  always_comb begin
    lines = '0;
    if (half == HALF_A) begin
      lines[OFS_A]  = sw;
      lines[OFS_AN] = ~sw;
    end else begin
      lines[OFS_B]  = sw;
      lines[OFS_BN] = ~sw;
    end
  end
endmodule

// File: rtl/seg_drtz_decoder.sv
module seg_drtz_decoder
  import seg_drtz_pkg::*;
#(
  parameter int THERM_W = 6,
  parameter int BIN_W   = 8,
  localparam int IN_W    = THERM_W + BIN_W,
  localparam int THERM_N = (1 << THERM_W) - 1,
  localparam int SW_N    = THERM_N + BIN_W,
  localparam int OUT_W   = SW_N * LINES_PER_SW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  sample_in,
  output logic             half_o,
  output logic [OUT_W-1:0] sw_bus
);
  half_e              half_q;
  half_e              half_nxt;
  logic [IN_W-1:0]    word_q;
  logic [THERM_N-1:0] therm;
  logic [SW_N-1:0]    sw_vec;
  logic [OUT_W-1:0]   lanes_c;

  seg_phase_ctl #(.WORD_W(IN_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .sample_in (sample_in),
    .half_q    (half_q),
    .word_q    (word_q)
  );

  seg_therm_dec #(.FIELD_W(THERM_W)) u_therm (
    .field (word_q[IN_W-1:BIN_W]),
    .therm (therm)
  );

  // Thermometer switches first, binary switches after them.
  assign sw_vec   = {word_q[BIN_W-1:0], therm};
  // The bus is loaded for the half that starts at the coming edge.
  assign half_nxt = (half_q == HALF_A) ? HALF_B : HALF_A;
  assign half_o   = half_q;

  for (genvar i = 0; i < SW_N; i++) begin : g_lane
    seg_drtz_lane u_lane (
      .sw    (sw_vec[i]),
      .half  (half_nxt),
      .lines (lanes_c[i*LINES_PER_SW +: LINES_PER_SW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sw_bus <= '0;
    else     sw_bus <= lanes_c;
  end

  for (genvar i = 0; i < SW_N; i++) begin : g_chk
    AST_QUIET_B: assert property (@(posedge clk) disable iff (rst)
      (half_o == 1'b0) |-> (sw_bus[i*LINES_PER_SW + OFS_B +: 2] == 2'b00)); // R5
    AST_QUIET_A: assert property (@(posedge clk) disable iff (rst)
      (half_o == 1'b1) |-> (sw_bus[i*LINES_PER_SW + OFS_A +: 2] == 2'b00)); // R6
    AST_ONE_LEG: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ($countones(sw_bus[i*LINES_PER_SW +: LINES_PER_SW]) == 1)); // R5
    AST_SAME_SAMPLE: assert property (@(posedge clk) disable iff (rst)
      (half_o == 1'b1 && !$past(rst)) |->
        (sw_bus[i*LINES_PER_SW + OFS_B] == $past(sw_bus[i*LINES_PER_SW + OFS_A]))); // R6
  end
endmodule

// File: tb/seg_drtz_decoder_bench.sv
module seg_drtz_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 14;
  localparam int NT = 63;
  localparam int NS = 71;
  localparam int OW = 284;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] sample_in = '0;
  logic          half_o;
  logic [OW-1:0] sw_bus;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_drtz_decoder u_seg_drtz_decoder (
    .clk       (clk),
    .rst       (rst),
    .sample_in (sample_in),
    .half_o    (half_o),
    .sw_bus    (sw_bus)
  );

  task automatic chk_num(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_bus(bit ok, string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] exp_bus(int code, bit second);
    logic [OW-1:0] b = '0;
    for (int s = 0; s < NS; s++) begin
      bit v = (s < NT) ? ((code >> 8) > s) : bit'((code >> (s - NT)) & 1);
      if (!second) begin b[4*s] = v; b[4*s+1] = !v; end
      else         begin b[4*s+2] = v; b[4*s+3] = !v; end
    end
    return b;
  endfunction

  function automatic int live(logic [OW-1:0] b, int s, bit second);
    return second ? int'(b[4*s+2]) : int'(b[4*s]);
  endfunction

  task automatic check_half(int code, bit second);
    int cnt = 0;
    int bin = 0;
    int sum = 0;
    for (int k = 0; k < NT; k++) cnt += live(sw_bus, k, second);
    for (int j = 0; j < 8; j++) bin += live(sw_bus, NT + j, second) << j;
    sum = cnt * 256 + bin;
    chk_num(half_o == second, "R2 half_o", int'(half_o), int'(second));
    if (!second) chk_bus(sw_bus == exp_bus(code, 0), "R5/R8 first-half bus", sw_bus, exp_bus(code, 0));
    else         chk_bus(sw_bus == exp_bus(code, 1), "R6 second-half bus", sw_bus, exp_bus(code, 1));
    chk_num(cnt == (code >> 8), "R3 thermometer count", cnt, code >> 8);
    chk_num(bin == (code & 255), "R4 binary field", bin, code & 255);
    chk_num(sum == code, "R7 weighted sum", sum, code);
  endtask

  initial begin
    int prev = -1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_bus(sw_bus == '0, "R1 bus in reset", sw_bus, '0);
    chk_num(half_o == 1'b0, "R1 half_o in reset", int'(half_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_num(half_o == 1'b1, "R2 first half_o after reset", int'(half_o), 1);
    @(negedge clk);
    chk_num(half_o == 1'b0, "R2 second half_o after reset", int'(half_o), 0);
    for (int c = 0; c <= 16384; c++) begin
      if (prev >= 0) check_half(prev, 0);
      sample_in = (c < 16384) ? IW'(c) : '0;
      @(negedge clk);
      if (prev >= 0) check_half(prev, 1);
      sample_in = ~sample_in; // R8: must not be captured
      @(negedge clk);
      prev = c;
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule